// File: doc/BRIEF.md
# Interrupt Status, Mask and Acknowledge Unit

This block holds the eight-bit interrupt status byte of a byte-addressed network controller. It also holds the eight-bit enable mask and drives a single level interrupt request. Other parts of the controller report events on one-cycle set pulses, and they can withdraw a bit they own on a matching clear pulse. Two status bits also follow queue state. The TX-empty bit is pressed on while the transmit queue is empty. The TX-done bit is pressed on while the completion queue holds any entry.

Software clears status by writing ones to the acknowledge offset. Only bits 7, 6, 4, 2 and 1 respond to that write; receive, allocation and PHY-event bits are owned by their sources. An acknowledge that carries bit 1 also removes the oldest completion-queue entry. It does this with a strobe to the queue owner, and the TX-done bit is evaluated against the depth that remains after that removal. The block decodes only its own two offsets: 12 for status and acknowledge, and 13 for the mask. Bank selection lives elsewhere.

Top module: `intc_status_unit`

## Requirements
- R1: After reset the status register holds 0x04, the mask holds 0x00 and `irq` is low.
- R2: Bit positions are 7 management, 6 early receive, 5 PHY event, 4 receive overrun, 3 allocation done, 2 TX empty, 1 TX done, 0 receive. A pulse on `set_evt[n]` makes bit n read 1 from the next cycle. Reads at offset 12 return the status, reads at offset 13 return the mask, and reads at any other offset return 0.
- R3: A status bit that is set stays set until a clear pulse or an acknowledge removes it.
- R4: A write to offset 12 clears exactly the status bits that are set both in the written byte and in 0xD6. Bits 5, 3 and 0 are unaffected by it.
- R5: A pulse on `clr_evt[n]` clears bit n. When a set pulse arrives in the same cycle as a clear pulse or an acknowledge of that bit, the set wins.
- R6: While `txq_empty` is high, bit 2 reads 1 and cannot be acknowledged away. Once the queue fills, bit 2 stays set until it is acknowledged.
- R7: While `done_cnt` is non-zero, bit 1 reads 1. An acknowledge with bit 1 set is judged against `done_cnt` minus the entry it pops, so popping the last entry lets bit 1 clear.
- R8: `done_pop` is high during a write to offset 12 whose byte has bit 1 set, and only while `done_cnt` is non-zero. It is never high otherwise.
- R9: `irq` is high exactly when the status AND the mask is non-zero. A mask write changes `irq` from the next cycle, which is the cycle the mask register updates.
- R10: A write to offset 13 stores the whole byte in the mask, and the mask reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Byte offset within the register window |
| reg_wr | input | 1 | Write strobe for `reg_addr`/`reg_wdata` |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for `reg_addr` (combinational) |
| set_evt | input | 8 | One-cycle set pulses, one per status bit |
| clr_evt | input | 8 | One-cycle clear pulses from the owners of each bit |
| txq_empty | input | 1 | Transmit queue is empty |
| done_cnt | input | 3 | Current completion-queue depth |
| done_pop | output | 1 | Remove the oldest completion entry |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the completion-queue owner lowers `done_cnt` by one on the edge where `done_pop` is high, and at no other time. They also assume that set and clear pulses last a single cycle. The stimulus keeps to this by changing `done_cnt` itself only after each popping write has been clocked. It drives every pulse, write and queue level on the falling edge and removes each pulse one cycle later. No acknowledge is issued while the queue depth is being changed.

// File: rtl/intc_status_pkg.sv
package intc_status_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BIT_MDIO  = 7;
  localparam int unsigned BIT_ERX   = 6;
  localparam int unsigned BIT_PHYEV = 5;
  localparam int unsigned BIT_OVRN  = 4;
  localparam int unsigned BIT_ALLOC = 3;
  localparam int unsigned BIT_TXE   = 2;
  localparam int unsigned BIT_TXD   = 1;
  localparam int unsigned BIT_RCV   = 0;
  // bits software may acknowledge
  localparam logic [STAT_W-1:0] ACKABLE    = 8'hD6;
  localparam logic [STAT_W-1:0] STAT_RESET = 8'h04;

  typedef struct packed {
    logic ack_wr;
    logic mask_wr;
    logic sel_stat;
    logic sel_mask;
  } intc_dec_t;
endpackage

// File: rtl/intc_addr_decode.sv
module intc_addr_decode
  import intc_status_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned OFS_STAT = 12,
  parameter int unsigned OFS_MASK = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output intc_dec_t         dec
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  always_comb begin
    dec.sel_stat = (addr == A_STAT);
    dec.sel_mask = (addr == A_MASK);
    dec.ack_wr   = wr && dec.sel_stat;
    dec.mask_wr  = wr && dec.sel_mask;
  end
endmodule

// File: rtl/intc_status_core.sv
module intc_status_core
  import intc_status_pkg::*;
#(
  parameter int unsigned DONE_CW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_wr,
  input  logic [STAT_W-1:0]  wdata,
  input  logic [STAT_W-1:0]  set_evt,
  input  logic [STAT_W-1:0]  clr_evt,
  input  logic               txq_empty,
  input  logic [DONE_CW-1:0] done_cnt,
  output logic [STAT_W-1:0]  status_view,
  output logic               done_pop
);
  logic [STAT_W-1:0]  stat_q, stat_d, clr_vec, force_now, force_nxt;
  logic [DONE_CW-1:0] cnt_after;
  logic               stat_en;

  always_comb begin
    done_pop  = ack_wr && wdata[BIT_TXD] && (done_cnt != '0);
    cnt_after = done_cnt - DONE_CW'(done_pop);
    force_now = '0;
    force_nxt = '0;
    force_now[BIT_TXE] = txq_empty;
    force_now[BIT_TXD] = (done_cnt != '0);
    force_nxt[BIT_TXE] = txq_empty;
    force_nxt[BIT_TXD] = (cnt_after != '0);
    clr_vec   = clr_evt | (ack_wr ? (wdata & ACKABLE) : '0);
    stat_d    = (stat_q & ~clr_vec) | set_evt | force_nxt;
    stat_en   = (stat_d != stat_q);
    status_view = stat_q | force_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STAT_RESET;
    else if (stat_en) stat_q <= stat_d;
  end

  // R6
  txe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |=> stat_q[BIT_TXE]);
  // R7
  txd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_cnt > DONE_CW'(1)) |=> stat_q[BIT_TXD]);
  // R4
  unackable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[BIT_RCV] && !clr_evt[BIT_RCV]) |=> stat_q[BIT_RCV]);
  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[BIT_MDIO] && !clr_evt[BIT_MDIO] && !(ack_wr && wdata[BIT_MDIO]))
      |=> stat_q[BIT_MDIO]);

  for (genvar i = 0; i < STAT_W; i++) begin : g_set_chk
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> stat_q[i]);
  end
endmodule

// File: rtl/intc_mask_irq.sv
module intc_mask_irq
  import intc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] status_view,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata;
  end

  always_comb begin
    mask = mask_q;
    irq  = |(status_view & mask_q);
  end

  // R9
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && wdata == '0) |=> !irq);
  // R10
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/intc_status_unit.sv
module intc_status_unit
  import intc_status_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DONE_CW  = 3,
  parameter int unsigned OFS_STAT = 12,
  parameter int unsigned OFS_MASK = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [STAT_W-1:0]  reg_wdata,
  output logic [STAT_W-1:0]  reg_rdata,
  input  logic [STAT_W-1:0]  set_evt,
  input  logic [STAT_W-1:0]  clr_evt,
  input  logic               txq_empty,
  input  logic [DONE_CW-1:0] done_cnt,
  output logic               done_pop,
  output logic               irq
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  intc_dec_t         dec;
  logic [STAT_W-1:0] status_view, mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  intc_addr_decode #(.ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .dec(dec)
  );

  intc_status_core #(.DONE_CW(DONE_CW)) u_core (
    .clk(clk), .rst_n(rst_int_n), .ack_wr(dec.ack_wr), .wdata(reg_wdata),
    .set_evt(set_evt), .clr_evt(clr_evt), .txq_empty(txq_empty),
    .done_cnt(done_cnt), .status_view(status_view), .done_pop(done_pop)
  );

  intc_mask_irq u_mask (
    .clk(clk), .rst_n(rst_int_n), .mask_wr(dec.mask_wr), .wdata(reg_wdata),
    .status_view(status_view), .mask(mask), .irq(irq)
  );

  always_comb begin
    if (dec.sel_stat)      reg_rdata = status_view;
    else if (dec.sel_mask) reg_rdata = mask;
    else                   reg_rdata = '0;
  end
endmodule

// File: tb/intc_status_unit_bench.sv
module intc_status_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata, set_evt, clr_evt;
  logic       txq_empty, done_pop, irq;
  logic [2:0] done_cnt;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  intc_status_unit u_intc_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_evt(set_evt),
    .clr_evt(clr_evt), .txq_empty(txq_empty), .done_cnt(done_cnt),
    .done_pop(done_pop), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, output logic pop);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    #1 pop = done_pop;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_set(input logic [7:0] v);
    @(negedge clk); set_evt = v; @(negedge clk); set_evt = '0;
  endtask

  task automatic pulse_clr(input logic [7:0] v);
    @(negedge clk); clr_evt = v; @(negedge clk); clr_evt = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'd12, d); chk("R1 status", d, 8'h04);
    rd(4'd13, d); chk("R1 mask", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_sticky;
    logic [7:0] d;
    pulse_set(8'h80);
    rd(4'd12, d); chk("R2 set mdio", d, 8'h84);
    rd(4'd5, d);  chk("R2 other offset", d, 8'h00);
    repeat (5) @(negedge clk);
    rd(4'd12, d); chk("R3 sticky", d, 8'h84);
  endtask

  task automatic t_ack_mask;
    logic [7:0] d; logic p;
    @(negedge clk); txq_empty = 1'b0;
    pulse_set(8'hFF);
    rd(4'd12, d); chk("R2 all set", d, 8'hFF);
    wr(4'd12, 8'hFF, p);
    rd(4'd12, d); chk("R4 ack only D6", d, 8'h29);
    chk("R8 no pop empty queue", {7'd0, p}, 8'h00);
  endtask

  task automatic t_txe;
    logic [7:0] d; logic p;
    @(negedge clk); txq_empty = 1'b1;
    @(negedge clk);
    wr(4'd12, 8'h04, p);
    rd(4'd12, d); chk("R6 forced through ack", d, 8'h2D);
    @(negedge clk); txq_empty = 1'b0;
    repeat (2) @(negedge clk);
    rd(4'd12, d); chk("R6 sticky after fill", d, 8'h2D);
    wr(4'd12, 8'h04, p);
    rd(4'd12, d); chk("R6 ack after fill", d, 8'h29);
  endtask

  task automatic t_clr;
    logic [7:0] d;
    pulse_clr(8'h29);
    rd(4'd12, d); chk("R5 clear pulse", d, 8'h00);
    @(negedge clk); set_evt = 8'h01; clr_evt = 8'h01;
    @(negedge clk); set_evt = '0; clr_evt = '0;
    rd(4'd12, d); chk("R5 set wins", d, 8'h01);
    pulse_clr(8'h01);
    rd(4'd12, d); chk("R5 clear rcv", d, 8'h00);
  endtask

  task automatic t_done;
    logic [7:0] d; logic p;
    @(negedge clk); done_cnt = 3'd2;
    rd(4'd12, d); chk("R7 forced by depth", d, 8'h02);
    wr(4'd12, 8'h02, p); done_cnt = 3'd1;
    chk("R8 pop strobe", {7'd0, p}, 8'h01);
    rd(4'd12, d); chk("R7 still pending", d, 8'h02);
    wr(4'd12, 8'h02, p); done_cnt = 3'd0;
    chk("R8 pop last", {7'd0, p}, 8'h01);
    rd(4'd12, d); chk("R7 cleared after last pop", d, 8'h00);
    wr(4'd12, 8'h02, p);
    chk("R8 no pop at zero", {7'd0, p}, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d; logic p;
    pulse_set(8'h10);
    chk("R9 masked off", {7'd0, irq}, 8'h00);
    wr(4'd13, 8'h10, p);
    chk("R9 irq on", {7'd0, irq}, 8'h01);
    rd(4'd13, d); chk("R10 mask readback", d, 8'h10);
    wr(4'd13, 8'hEF, p);
    chk("R9 irq off other bits", {7'd0, irq}, 8'h00);
    rd(4'd13, d); chk("R10 full byte", d, 8'hEF);
    wr(4'd13, 8'h00, p);
    rd(4'd13, d); chk("R10 zero", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    set_evt = '0; clr_evt = '0; txq_empty = 1'b1; done_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_set_sticky;
    t_ack_mask;
    t_txe;
    t_clr;
    t_done;
    t_irq;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule